// File: doc/BRIEF.md
# Internal Oscillator Clock Controller

This block chooses the main clock from a fast internal oscillator, a slow internal oscillator or an external clock. It also makes a peripheral reference clock from the slow oscillator through two power-of-two dividers in series. The slow oscillator has two frequency settings, picked by a range bit. The output of the first divider goes to the main source mux and also feeds the second divider. The output of the second divider, gated by an enable bit, is the peripheral clock.

The oscillators are modelled as level inputs that a faster sampling clock `clk` captures, so all state sits in one clock domain. A source switch runs as a handshake. The old source is first parked low. The controller then waits for two rising edges of the new source and for that source to go low, and only then releases the output. A read-only status field reports the source that is actually driving the output, and software polls it.

A stop request turns the fast oscillator off. The slow oscillator keeps running through stop only if the stop-keep bit and the internal-clock enable bit were both set when stop began.

Top module: `irc_clock_ctrl`

## Requirements
- R1: After reset, address 0 reads 0, address 1 reads 0, address 2 reads 0 and address 3 (status) reads 0. The fast oscillator drives the main clock, so the main period equals the fast input's period. The peripheral clock stays low.
- R2: The select field is address 0 bits [1:0]. Code 00 routes the fast oscillator to the main clock, code 01 routes the first divider's output, and code 10 routes the external clock. The main clock then has the period of the chosen source.
- R3: A write of select code 11 leaves the stored select field and the status unchanged. The other bits of the same write still take effect: bit 2 is the internal-clock enable and bit 3 is the stop-keep bit.
- R4: The status (`activeSrc`, and address 3 bits [1:0]) keeps the old source in the cycle after a select write. It changes to the new code only after at least two rising edges of the new source have been seen.
- R5: The range bit is address 1 bit 0. Value 0 takes the slow oscillator from the 2 MHz input and value 1 takes it from the 8 MHz input.
- R6: The first divider's factor is 2^k1, where k1 is address 1 bits [3:1]. With code 01 selected, the main period is the slow period times 2^k1.
- R7: The second divider's factor is 2^k2, where k2 is address 2 bits [2:0]. It divides the first divider's output, so the peripheral period is the slow period times 2^(k1+k2), with a high time of exactly half the period.
- R8: A change of division factor takes effect at a rising edge of the divider output. No high pulse is shorter than the smaller of the old and new half periods.
- R9: When the internal-clock enable is 0, the peripheral clock is held low.
- R10: While stop is requested, `fastOscEn` is 0 and the main clock is held low if the fast source is selected.
- R11: During stop, `slowOscEn` stays 1 and the peripheral clock keeps toggling only if both the stop-keep bit and the internal-clock enable bit were set when stop was entered. Otherwise `slowOscEn` is 0 and the peripheral clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rstN | input | 1 | Active-low asynchronous reset |
| fastOscIn | input | 1 | Fast internal oscillator level |
| slowOsc2mIn | input | 1 | Slow oscillator, low-range level |
| slowOsc8mIn | input | 1 | Slow oscillator, high-range level |
| extClkIn | input | 1 | External clock level |
| stopReq | input | 1 | Stop mode request |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data for regAddr |
| mainClkOut | output | 1 | Selected main clock |
| periphClkOut | output | 1 | Peripheral reference clock |
| activeSrc | output | 2 | Source currently driving the main clock |
| fastOscEn | output | 1 | Fast oscillator enable |
| slowOscEn | output | 1 | Slow oscillator enable |

## Verification
The bench checks the reserved select code. A design that stores that code would leave the main output dead and report a status that matches no source. It reads the status in the cycle right after a select write, and measures the time the switch takes. A mux that reports early, or that skips the synchronisation on the new source, would show the new code at once. It records the shortest high pulse across a factor change, because a divider that reloads mid-count gives a runt. It also enters stop with only one of the two keep bits set, where a design that checks a single bit would leave the slow oscillator running.

// File: rtl/irc_clk_pkg.sv
package irc_clk_pkg;
  localparam int REG_DW = 4;
  localparam int DIV_W  = 3;

  localparam logic [1:0] SRC_FAST = 2'b00;
  localparam logic [1:0] SRC_SLOW = 2'b01;
  localparam logic [1:0] SRC_EXT  = 2'b10;
  localparam logic [1:0] SRC_RSVD = 2'b11;

  typedef enum logic [1:0] {SW_IDLE, SW_DRAIN, SW_SYNC, SW_ARM} sw_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [1:0]       curSrc;
    logic             gateOn;
    logic             rangeSel;
    logic [DIV_W-1:0] div1K;
    logic [DIV_W-1:0] div2K;
    logic             irclkEn;
    logic             fastRun;
    logic             slowRun;
  } ctrl_strobe_t;

  // datapath -> control observations; index 0 fast, 1 divided slow, 2 external
  typedef struct packed {
    logic [2:0] lvl;
    logic [2:0] rise;
  } src_obs_t;

  function automatic logic pickSrc(input logic [2:0] v, input logic [1:0] s);
    case (s)
      SRC_FAST: return v[0];
      SRC_SLOW: return v[1];
      SRC_EXT:  return v[2];
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irc_pow2_div.sv
module irc_pow2_div #(
  parameter int K_W = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           srcLvl,
  input  logic [K_W-1:0] newK,
  output logic           outLvl
);
  localparam int CNT_RAW = (1 << K_W) - 2;
  localparam int CNT_W   = (CNT_RAW > 0) ? CNT_RAW : 1;

  logic             srcPrev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfM1;
  logic [K_W-1:0]   curK;
  logic             srcRise;

  assign srcRise = srcLvl & ~srcPrev;

  always_comb begin
    halfM1 = '0;
    for (int i = 1; i < (1 << K_W); i++) begin
      if (curK == K_W'(i)) halfM1 = CNT_W'((1 << (i - 1)) - 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= 1'b0;
      cnt     <= '0;
      curK    <= '0;
      outLvl  <= 1'b0;
    end else begin
      srcPrev <= srcLvl;
      if (curK == '0) begin
        outLvl <= srcLvl;
        if (srcRise) begin
          curK <= newK;
          cnt  <= '0;
        end
      end else if (srcRise) begin
        if (cnt == halfM1) begin
          cnt    <= '0;
          outLvl <= ~outLvl;
          if (!outLvl) curK <= newK;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DIV_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curK) |-> $rose(outLvl)); // R8
endmodule

// File: rtl/irc_clk_datapath.sv
module irc_clk_datapath
  import irc_clk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fastOscIn,
  input  logic         slowOsc2mIn,
  input  logic         slowOsc8mIn,
  input  logic         extClkIn,
  input  ctrl_strobe_t strobe,
  output src_obs_t     obs,
  output logic         mainClk,
  output logic         periphClk
);
  localparam int STAGES = 2;

  logic fastLvl, slowLvl, extLvl;
  logic [2:0] lvlPrev;
  logic [STAGES-1:0] stageIn, stageOut;
  logic [STAGES-1:0][DIV_W-1:0] stageK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastLvl <= 1'b0;
      slowLvl <= 1'b0;
      extLvl  <= 1'b0;
      lvlPrev <= '0;
    end else begin
      fastLvl <= fastOscIn & strobe.fastRun;
      slowLvl <= (strobe.rangeSel ? slowOsc8mIn : slowOsc2mIn) & strobe.slowRun;
      extLvl  <= extClkIn;
      lvlPrev <= obs.lvl;
    end
  end

  assign stageIn[0] = slowLvl;
  assign stageIn[1] = stageOut[0];
  assign stageK[0]  = strobe.div1K;
  assign stageK[1]  = strobe.div2K;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    irc_pow2_div #(.K_W(DIV_W)) i_div (
      .clk   (clk),
      .rstN  (rstN),
      .srcLvl(stageIn[g]),
      .newK  (stageK[g]),
      .outLvl(stageOut[g])
    );
  end

  assign obs.lvl  = {extLvl, stageOut[0], fastLvl};
  assign obs.rise = obs.lvl & ~lvlPrev;

  assign mainClk   = strobe.gateOn & pickSrc(obs.lvl, strobe.curSrc);
  assign periphClk = stageOut[STAGES-1] & strobe.irclkEn;

  AST_FAST_OFF_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fastRun |=> !fastLvl); // R10
  AST_SLOW_OFF_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.slowRun |=> !slowLvl); // R11
endmodule

// File: rtl/irc_clk_control.sv
module irc_clk_control
  import irc_clk_pkg::*;
#(
  parameter int SYNC_EDGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  src_obs_t          obs,
  output ctrl_strobe_t      strobe,
  output logic [REG_DW-1:0] regRdData,
  output logic [1:0]        activeSrc,
  output logic              fastOscEn,
  output logic              slowOscEn
);
  localparam int SC_W = $clog2(SYNC_EDGES + 1);

  logic [1:0]       srcSel, curSrc, swTarget;
  logic             irclkEn, stopKeep, rangeSel, gateOn;
  logic [DIV_W-1:0] div1K, div2K;
  logic             stopQ, keepLatched, keepNow;
  logic [SC_W-1:0]  syncCnt;
  sw_state_e        swState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel   <= SRC_FAST;
      irclkEn  <= 1'b0;
      stopKeep <= 1'b0;
      rangeSel <= 1'b0;
      div1K    <= '0;
      div2K    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        2'd0: begin
          if (regWrData[1:0] != SRC_RSVD) srcSel <= regWrData[1:0];
          irclkEn  <= regWrData[2];
          stopKeep <= regWrData[3];
        end
        2'd1: begin
          rangeSel <= regWrData[0];
          div1K    <= regWrData[3:1];
        end
        2'd2: div2K <= regWrData[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = {stopKeep, irclkEn, srcSel};
      2'd1:    regRdData = {div1K, rangeSel};
      2'd2:    regRdData = {1'b0, div2K};
      default: regRdData = {2'b00, curSrc};
    endcase
  end

  // stop-mode retention: both bits sampled on stop entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ       <= 1'b0;
      keepLatched <= 1'b0;
    end else begin
      stopQ <= stopReq;
      if (stopReq && !stopQ) keepLatched <= stopKeep & irclkEn;
    end
  end

  assign keepNow   = stopQ ? keepLatched : (stopKeep & irclkEn);
  assign fastOscEn = !stopReq;
  assign slowOscEn = !stopReq | keepNow;

  // source switch handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swState  <= SW_IDLE;
      curSrc   <= SRC_FAST;
      swTarget <= SRC_FAST;
      gateOn   <= 1'b1;
      syncCnt  <= '0;
    end else begin
      case (swState)
        SW_IDLE: if (srcSel != curSrc) begin
          swTarget <= srcSel;
          swState  <= SW_DRAIN;
        end
        SW_DRAIN: if (!pickSrc(obs.lvl, curSrc)) begin
          gateOn  <= 1'b0;
          syncCnt <= '0;
          swState <= SW_SYNC;
        end
        SW_SYNC: if (pickSrc(obs.rise, swTarget)) begin
          if (syncCnt == SC_W'(SYNC_EDGES - 1)) swState <= SW_ARM;
          else syncCnt <= syncCnt + 1'b1;
        end
        default: if (!pickSrc(obs.lvl, swTarget)) begin
          curSrc  <= swTarget;
          gateOn  <= 1'b1;
          swState <= SW_IDLE;
        end
      endcase
    end
  end

  assign activeSrc = curSrc;

  assign strobe.curSrc   = curSrc;
  assign strobe.gateOn   = gateOn;
  assign strobe.rangeSel = rangeSel;
  assign strobe.div1K    = div1K;
  assign strobe.div2K    = div2K;
  assign strobe.irclkEn  = irclkEn;
  assign strobe.fastRun  = !stopReq;
  assign strobe.slowRun  = slowOscEn;

  AST_SEL_DEFINED: assert property (@(posedge clk) disable iff (!rstN)
    srcSel != SRC_RSVD); // R3
  AST_STATUS_DEFINED: assert property (@(posedge clk) disable iff (!rstN)
    activeSrc != SRC_RSVD); // R3
  AST_STATUS_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curSrc) |-> $past(swState) == SW_ARM); // R4
  AST_STATUS_TRACKS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curSrc) |-> curSrc == $past(swTarget)); // R4
endmodule

// File: rtl/irc_clock_ctrl.sv
module irc_clock_ctrl
  import irc_clk_pkg::*;
#(
  parameter int SYNC_EDGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastOscIn,
  input  logic              slowOsc2mIn,
  input  logic              slowOsc8mIn,
  input  logic              extClkIn,
  input  logic              stopReq,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  output logic              mainClkOut,
  output logic              periphClkOut,
  output logic [1:0]        activeSrc,
  output logic              fastOscEn,
  output logic              slowOscEn
);
  ctrl_strobe_t strobe;
  src_obs_t     obs;

  irc_clk_control #(.SYNC_EDGES(SYNC_EDGES)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .stopReq  (stopReq),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .obs      (obs),
    .strobe   (strobe),
    .regRdData(regRdData),
    .activeSrc(activeSrc),
    .fastOscEn(fastOscEn),
    .slowOscEn(slowOscEn)
  );

  irc_clk_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .fastOscIn  (fastOscIn),
    .slowOsc2mIn(slowOsc2mIn),
    .slowOsc8mIn(slowOsc8mIn),
    .extClkIn   (extClkIn),
    .strobe     (strobe),
    .obs        (obs),
    .mainClk    (mainClkOut),
    .periphClk  (periphClkOut)
  );
endmodule

// File: tb/test_irc_clock_ctrl.sv
module test_irc_clock_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastOscIn = 1'b0, slowOsc2mIn = 1'b0, slowOsc8mIn = 1'b0, extClkIn = 1'b0;
  logic stopReq = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [3:0] regWrData = 4'd0;
  logic [3:0] regRdData;
  logic mainClkOut, periphClkOut, fastOscEn, slowOscEn;
  logic [1:0] activeSrc;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irc_clock_ctrl i_irc_clock_ctrl (
    .clk(clk), .rstN(rstN), .fastOscIn(fastOscIn), .slowOsc2mIn(slowOsc2mIn),
    .slowOsc8mIn(slowOsc8mIn), .extClkIn(extClkIn), .stopReq(stopReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .mainClkOut(mainClkOut), .periphClkOut(periphClkOut),
    .activeSrc(activeSrc), .fastOscEn(fastOscEn), .slowOscEn(slowOscEn)
  );

  // oscillator models: fast period 2, 8M period 4, 2M period 16, ext period 6
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase++;
      fastOscIn   = phase[0];
      slowOsc8mIn = phase[1];
      slowOsc2mIn = phase[3];
      extClkIn    = (phase % 6) < 3;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    regAddr = a;
    #1 v = int'(regRdData);
  endtask

  function automatic logic sig(input int which);
    return (which == 0) ? mainClkOut : periphClkOut;
  endfunction

  // skip two rises, then measure one full period and its high time
  task automatic measure(input int which, output int per, output int hi);
    int rises = 0, t = 0;
    logic p, c;
    per = 0; hi = 0;
    p = sig(which);
    while (rises < 4 && t < 40000) begin
      @(negedge clk);
      t++;
      c = sig(which);
      if (c && !p) rises++;
      if (rises == 3) begin
        per++;
        if (c) hi++;
      end
      p = c;
    end
    if (rises < 4) begin per = 0; hi = 0; end
  endtask

  task automatic countRises(input int which, input int win, output int n);
    logic p, c;
    n = 0;
    p = sig(which);
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      c = sig(which);
      if (c && !p) n++;
      p = c;
    end
  endtask

  task automatic waitStatus(input logic [1:0] want, output int cyc);
    cyc = 0;
    while (activeSrc != want && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // {range, k1, k2, periph period, main period}
  typedef struct packed {
    logic       range;
    logic [2:0] k1;
    logic [2:0] k2;
    int         perP;
    int         perM;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd0, 3'd0, 16,   16},
    '{1'b1, 3'd0, 3'd0, 4,    4},
    '{1'b1, 3'd1, 3'd0, 8,    8},
    '{1'b1, 3'd2, 3'd1, 32,   16},
    '{1'b1, 3'd0, 3'd3, 32,   4},
    '{1'b0, 3'd3, 3'd2, 512,  128},
    '{1'b1, 3'd7, 3'd0, 512,  512},
    '{1'b0, 3'd2, 3'd4, 1024, 64}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, per, hi, cyc, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg reset", v, 0);
    end
    check("R1 status reset", int'(activeSrc), 0);
    measure(0, per, hi);
    check("R1 main on fast", per, 2);
    countRises(1, 60, n);
    check("R9 periph low when disabled", n, 0);

    // R4 switch to slow with enable on
    wr(2'd0, 4'b0101);
    check("R4 status held after write", int'(activeSrc), 0);
    waitStatus(2'b01, cyc);
    check("R4 status reports slow", int'(activeSrc), 1);
    check("R4 sync takes two slow rises", int'(cyc >= 16), 1);

    // R5 R6 R7 vector walk
    foreach (VECS[i]) begin
      wr(2'd1, {VECS[i].k1, VECS[i].range});
      wr(2'd2, {1'b0, VECS[i].k2});
      measure(1, per, hi);
      check("R7 periph period", per, VECS[i].perP);
      check("R7 periph high half", hi, VECS[i].perP / 2);
      measure(0, per, hi);
      check("R6 main period on slow", per, VECS[i].perM);
    end
    wr(2'd1, 4'b0000);
    wr(2'd2, 4'b0000);
    measure(1, per, hi);
    check("R5 range 0 uses 2M input", per, 16);
    wr(2'd1, 4'b0001);
    measure(1, per, hi);
    check("R5 range 1 uses 8M input", per, 4);

    // R3 reserved select code
    wr(2'd0, 4'b0111);
    rd(2'd0, v);
    check("R3 select kept on code 11", v, 5);
    repeat (40) @(negedge clk);
    check("R3 status kept on code 11", int'(activeSrc), 1);
    wr(2'd0, 4'b0011);
    rd(2'd0, v);
    check("R3 other bits applied", v, 1);
    countRises(1, 60, n);
    check("R9 periph held low", n, 0);

    // R2 external and fast
    wr(2'd0, 4'b0110);
    waitStatus(2'b10, cyc);
    check("R2 status ext", int'(activeSrc), 2);
    measure(0, per, hi);
    check("R2 main ext period", per, 6);
    check("R2 main ext high", hi, 3);
    wr(2'd0, 4'b0100);
    waitStatus(2'b00, cyc);
    rd(2'd3, v);
    check("R2 status reg fast", v, 0);
    measure(0, per, hi);
    check("R2 main fast period", per, 2);

    // R8 factor change without runt
    wr(2'd2, 4'b0011);
    measure(1, per, hi);
    check("R8 periph before change", per, 32);
    wr(2'd2, 4'b0000);
    begin
      int run = 0, minHi = 1000;
      logic p = periphClkOut;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (periphClkOut) run++;
        else begin
          if (p && run < minHi) minHi = run;
          run = 0;
        end
        p = periphClkOut;
      end
      check("R8 no runt high pulse", int'(minHi >= 2), 1);
    end
    measure(1, per, hi);
    check("R8 new factor period", per, 4);

    // R10 R11 stop with both keep bits
    wr(2'd0, 4'b1100);
    @(negedge clk);
    stopReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 fast enable off", int'(fastOscEn), 0);
    countRises(0, 40, n);
    check("R10 main held low", n, 0);
    check("R11 slow kept with both bits", int'(slowOscEn), 1);
    countRises(1, 40, n);
    check("R11 periph alive in stop", int'(n > 0), 1);
    stopReq = 1'b0;

    // R11 enable only
    wr(2'd0, 4'b0100);
    @(negedge clk);
    stopReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 slow off with enable only", int'(slowOscEn), 0);
    countRises(1, 40, n);
    check("R11 periph stopped", n, 0);
    stopReq = 1'b0;

    // R11 keep only
    wr(2'd0, 4'b1000);
    @(negedge clk);
    stopReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 slow off with keep only", int'(slowOscEn), 0);
    stopReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 fast enable back after stop", int'(fastOscEn), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule